// File: doc/BRIEF.md
# NAND Page-Read Command Sequencer

This block runs one page-read transaction on a raw 8-bit NAND flash bus for a device whose error correction is built into the die. On a request it drives the read opening command, the column and page address bytes and the read-confirm command. Then it repeatedly asks the device for its status byte until the device reports ready, or until a fixed number of tries has run out. It sorts the final status into two running counters, one for reads the device had to correct and one for reads it could not correct. Last, it puts the device back into data-output mode with one more read command and waits for the ready/busy line before it reports completion.

A caller hands over a page address, a column, a bus-width flag, a large-device flag and a spare-area flag on a valid/ready handshake. When the transaction ends, the block returns a single-cycle done pulse together with the last status byte. The caller then clocks the page data out through its own path. Reading the spare area needs no separate flow: it is an ordinary page read whose column is moved past the main page by `PAGE_BYTES`. All delays are counted in clock cycles, and the default values assume a 100 MHz clock.

Top module: `nand_pgrd_seq`

## Requirements
- R1: A transaction latches, in this order: command 0x00 (command latch high), column low byte, column high byte, page byte 0 (bits 7:0), page byte 1 (bits 15:8) (address latch high), then command 0x30. Every byte is taken on the rising edge of `nand_we_n`.
- R2: Page byte 2 (bits 23:16) is sent between page byte 1 and 0x30 only when `req_big` is 1.
- R3: When `req_wide` is 1, the column that is sent is the effective column shifted right by one bit.
- R4: When `req_spare` is 1, the effective column is `req_col + PAGE_BYTES`, and the bus-width shift is applied after this addition.
- R5: After 0x30 the block repeats the following: wait `POLL_GAP_CYC` cycles, latch command 0x70, read one status byte with `nand_re_n` low. It stops after the first status byte whose bit 6 (ready) is 1, or after `POLL_MAX` reads.
- R6: In the final status byte, bit 0 adds one to `ecc_fail_cnt` and bit 3 adds one to `ecc_fix_cnt`. When both bits are set, both counters advance on the same read.
- R7: If `POLL_MAX` status reads pass without the ready bit, `poll_timeout` is set and stays set until reset. The transaction still completes, and the last byte is still decoded.
- R8: After polling ends, exactly one more command 0x00 is latched, with no address bytes.
- R9: `done` rises no sooner than `TWB_CYC` cycles after the last 0x00 is latched, and only after `nand_rdy` has been seen high. It lasts one cycle, and `done_status` then carries the last status byte.
- R10: `req_ready` is 1 only while idle. A request raised during a transaction is ignored and causes no bus activity.
- R11: After reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale` and `nand_dq_oe` are 0, both counters and `poll_timeout` are 0, and `req_ready` is 1.
- R12: `nand_cle` and `nand_ale` are never both 1. `nand_we_n` and `nand_re_n` are never both low. The byte lane is not driven while `nand_re_n` is low, and either strobe is low only while `nand_ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting |
| req_page | input | 24 | Page (row) address |
| req_col | input | 16 | Byte column within the page |
| req_wide | input | 1 | Device has a 16-bit data bus |
| req_big | input | 1 | Device capacity above 128 MiB (third page byte needed) |
| req_spare | input | 1 | Read the spare area (column offset by the page size) |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 8 | Last status byte read |
| ecc_fix_cnt | output | CNT_W | Reads the device corrected |
| ecc_fail_cnt | output | CNT_W | Reads the device could not correct |
| poll_timeout | output | 1 | Sticky: a poll loop ran out |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte lane, driven value |
| nand_dq_oe | output | 1 | Byte lane drive enable |
| nand_dq_in | input | 8 | Byte lane, sampled value |
| nand_rdy | input | 1 | Device ready/busy, high when ready |

## Verification
The transactions combine small and large devices, byte and word buses, and main-area and spare-area columns. Together these separate the third-page-byte rule, the column shift, and the order of the offset and the shift. The device model holds its ready bit back for zero, a few, or more than `POLL_MAX` polls, and it reports no error, a correction, a failure, or both. This tells early poll exit apart from the timeout path and checks that each status bit goes to the right counter. The model also drops ready/busy shortly after the closing read command, and one run leaves it high, so that the ready wait and the `TWB_CYC` floor are each seen to bound `done`. A request raised in the middle of a transaction shows whether the handshake really blocks it.

// File: rtl/nand_pgrd_seq.sv
module nand_pgrd_seq #(
  parameter int CNT_W        = 16,
  parameter int PAGE_BYTES   = 2048,
  parameter int POLL_MAX     = 70,
  parameter int POLL_GAP_CYC = 100,
  parameter int TWB_CYC      = 10,
  parameter int WE_LO_CYC    = 2,
  parameter int WE_HI_CYC    = 2,
  parameter int RE_LO_CYC    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_page,
  input  logic [15:0]      req_col,
  input  logic             req_wide,
  input  logic             req_big,
  input  logic             req_spare,
  output logic             done,
  output logic [7:0]       done_status,
  output logic [CNT_W-1:0] ecc_fix_cnt,
  output logic [CNT_W-1:0] ecc_fail_cnt,
  output logic             poll_timeout,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_out,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_in,
  input  logic             nand_rdy
);

  localparam int M1   = (POLL_GAP_CYC > TWB_CYC) ? POLL_GAP_CYC : TWB_CYC;
  localparam int M2   = (M1 > WE_LO_CYC) ? M1 : WE_LO_CYC;
  localparam int M3   = (M2 > WE_HI_CYC) ? M2 : WE_HI_CYC;
  localparam int MAXD = (M3 > RE_LO_CYC) ? M3 : RE_LO_CYC;
  localparam int CW   = $clog2(MAXD + 1);
  localparam int PW   = $clog2(POLL_MAX + 1);

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_CONFIRM = 8'h30;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam int         BIT_FAIL   = 0;
  localparam int         BIT_FIX    = 3;
  localparam int         BIT_RDY    = 6;

  localparam logic [3:0] ST_OPEN  = 4'd0;
  localparam logic [3:0] ST_CLO   = 4'd1;
  localparam logic [3:0] ST_CHI   = 4'd2;
  localparam logic [3:0] ST_P0    = 4'd3;
  localparam logic [3:0] ST_P1    = 4'd4;
  localparam logic [3:0] ST_P2    = 4'd5;
  localparam logic [3:0] ST_CONF  = 4'd6;
  localparam logic [3:0] ST_POLL  = 4'd7;
  localparam logic [3:0] ST_CLOSE = 4'd8;

  typedef enum logic [3:0] {
    S_IDLE, S_WLO, S_WHI, S_GAP, S_RLO, S_RHI, S_TWB, S_WRDY, S_DONE
  } state_t;

  state_t          state, state_d;
  logic [3:0]      step, step_d;
  logic [CW-1:0]   cnt, cnt_d;
  logic [PW-1:0]   poll_n;
  logic [15:0]     col_q;
  logic [23:0]     row_q;
  logic            big_q;
  logic [7:0]      stat_q;
  logic [16:0]     col_sum;
  logic [15:0]     col_eff;
  logic            last_poll, poll_end, is_cmd_d, wr_d;
  logic [7:0]      byte_d;

  assign col_sum   = {1'b0, req_col} + (req_spare ? 17'(PAGE_BYTES) : 17'd0);
  assign col_eff   = req_wide ? col_sum[16:1] : col_sum[15:0];
  assign last_poll = (poll_n == PW'(POLL_MAX - 1));
  assign poll_end  = nand_dq_in[BIT_RDY] || last_poll;

  assign req_ready   = (state == S_IDLE);
  assign done        = (state == S_DONE);
  assign done_status = stat_q;

  always_comb begin
    state_d = state;
    step_d  = step;
    cnt_d   = (cnt != '0) ? cnt - 1'b1 : cnt;
    case (state)
      S_IDLE: if (req_valid) begin
        state_d = S_WLO; step_d = ST_OPEN; cnt_d = CW'(WE_LO_CYC - 1);
      end
      S_WLO: if (cnt == '0) begin
        state_d = S_WHI; cnt_d = CW'(WE_HI_CYC - 1);
      end
      S_WHI: if (cnt == '0) begin
        state_d = S_WLO;
        cnt_d   = CW'(WE_LO_CYC - 1);
        case (step)
          ST_P1:    step_d = big_q ? ST_P2 : ST_CONF;
          ST_CONF:  begin state_d = S_GAP; step_d = ST_POLL; cnt_d = CW'(POLL_GAP_CYC - 1); end
          ST_POLL:  begin state_d = S_RLO; cnt_d = CW'(RE_LO_CYC - 1); end
          ST_CLOSE: begin state_d = S_TWB; cnt_d = CW'(TWB_CYC - 1); end
          default:  step_d = step + 4'd1;
        endcase
      end
      S_GAP: if (cnt == '0) begin
        state_d = S_WLO; cnt_d = CW'(WE_LO_CYC - 1);
      end
      S_RLO: if (cnt == '0) begin
        state_d = S_RHI; cnt_d = CW'(WE_HI_CYC - 1);
        step_d  = poll_end ? ST_CLOSE : ST_POLL;
      end
      S_RHI: if (cnt == '0) begin
        if (step == ST_CLOSE) begin
          state_d = S_WLO; cnt_d = CW'(WE_LO_CYC - 1);
        end else begin
          state_d = S_GAP; cnt_d = CW'(POLL_GAP_CYC - 1);
        end
      end
      S_TWB:  if (cnt == '0) state_d = S_WRDY;
      S_WRDY: if (nand_rdy) state_d = S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    case (step_d)
      ST_CLO:  byte_d = col_q[7:0];
      ST_CHI:  byte_d = col_q[15:8];
      ST_P0:   byte_d = row_q[7:0];
      ST_P1:   byte_d = row_q[15:8];
      ST_P2:   byte_d = row_q[23:16];
      ST_CONF: byte_d = OP_CONFIRM;
      ST_POLL: byte_d = OP_STATUS;
      default: byte_d = OP_READ;
    endcase
  end

  assign is_cmd_d = (step_d == ST_OPEN) || (step_d == ST_CONF) ||
                    (step_d == ST_POLL) || (step_d == ST_CLOSE);
  assign wr_d     = (state_d == S_WLO) || (state_d == S_WHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      step  <= ST_OPEN;
      cnt   <= '0;
    end else begin
      state <= state_d;
      step  <= step_d;
      cnt   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nand_ce_n   <= 1'b1;
      nand_we_n   <= 1'b1;
      nand_re_n   <= 1'b1;
      nand_cle    <= 1'b0;
      nand_ale    <= 1'b0;
      nand_dq_oe  <= 1'b0;
      nand_dq_out <= 8'h00;
    end else begin
      nand_ce_n   <= (state_d == S_IDLE);
      nand_we_n   <= (state_d != S_WLO);
      nand_re_n   <= (state_d != S_RLO);
      nand_cle    <= wr_d && is_cmd_d;
      nand_ale    <= wr_d && !is_cmd_d;
      nand_dq_oe  <= wr_d;
      nand_dq_out <= wr_d ? byte_d : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q        <= '0;
      row_q        <= '0;
      big_q        <= 1'b0;
      poll_n       <= '0;
      stat_q       <= 8'h00;
      ecc_fix_cnt  <= '0;
      ecc_fail_cnt <= '0;
      poll_timeout <= 1'b0;
    end else begin
      if (state == S_IDLE && req_valid) begin
        col_q  <= col_eff;
        row_q  <= req_page;
        big_q  <= req_big;
        poll_n <= '0;
      end
      if (state == S_RLO && cnt == '0) begin
        stat_q <= nand_dq_in;
        poll_n <= poll_n + 1'b1;
        if (poll_end) begin
          if (nand_dq_in[BIT_FAIL]) ecc_fail_cnt <= ecc_fail_cnt + 1'b1;
          if (nand_dq_in[BIT_FIX])  ecc_fix_cnt  <= ecc_fix_cnt + 1'b1;
          if (!nand_dq_in[BIT_RDY]) poll_timeout <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/nand_pgrd_seq_chk.sv
module nand_pgrd_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             done,
  input logic [CNT_W-1:0] ecc_fix_cnt,
  input logic [CNT_W-1:0] ecc_fail_cnt,
  input logic             poll_timeout,
  input logic             nand_ce_n,
  input logic             nand_cle,
  input logic             nand_ale,
  input logic             nand_we_n,
  input logic             nand_re_n,
  input logic             nand_dq_oe,
  input logic             nand_rdy
);

  assert_latch_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  assert_no_drive_on_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  assert_strobe_selected_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_rdy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(nand_rdy));

  assert_busy_blocks_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle || nand_ale) |-> !req_ready);

  assert_timeout_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_timeout |=> poll_timeout);

  assert_fail_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_fail_cnt != $past(ecc_fail_cnt)) |-> (ecc_fail_cnt == $past(ecc_fail_cnt) + CNT_W'(1)));

  assert_fix_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_fix_cnt != $past(ecc_fix_cnt)) |-> (ecc_fix_cnt == $past(ecc_fix_cnt) + CNT_W'(1)));

endmodule

bind nand_pgrd_seq nand_pgrd_seq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .ecc_fix_cnt(ecc_fix_cnt), .ecc_fail_cnt(ecc_fail_cnt),
  .poll_timeout(poll_timeout), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_dq_oe(nand_dq_oe), .nand_rdy(nand_rdy)
);

// File: tb/nand_pgrd_seq_tb_top.sv
`timescale 1ns/1ps
module nand_pgrd_seq_tb_top;
  localparam int CNT_W    = 16;
  localparam int PAGE_B   = 2048;
  localparam int PMAX     = 70;
  localparam int TWB      = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [23:0] req_page = '0;
  logic [15:0] req_col = '0;
  logic req_wide = 1'b0, req_big = 1'b0, req_spare = 1'b0;
  logic done;
  logic [7:0] done_status;
  logic [CNT_W-1:0] ecc_fix_cnt, ecc_fail_cnt;
  logic poll_timeout, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] nand_dq_out;
  logic [7:0] stat = 8'h80;
  logic nand_rdy = 1'b1;

  always #4 clk = ~clk;

  nand_pgrd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_col(req_col), .req_wide(req_wide), .req_big(req_big),
    .req_spare(req_spare), .done(done), .done_status(done_status),
    .ecc_fix_cnt(ecc_fix_cnt), .ecc_fail_cnt(ecc_fail_cnt), .poll_timeout(poll_timeout),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(stat), .nand_rdy(nand_rdy)
  );

  int vectors = 0, miscompares = 0;
  logic [9:0] expq[$];
  string      tagq[$];
  int  busy_k = 0, rdy_len = 0, pc = 0;
  logic [7:0] ecc_v = 8'h00;
  bit  confirmed = 0;
  time t_final = 0;
  int  exp_fix = 0, exp_fail = 0;
  bit  exp_to = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input bit c, input bit a, input logic [7:0] b, input string tag);
    expq.push_back({c, a, b});
    tagq.push_back(tag);
  endtask

  // monitor and device model: each latched byte is compared against the queue
  always @(posedge nand_we_n) if (rst_n) begin
    logic [9:0] item;
    item = {nand_cle, nand_ale, nand_dq_out};
    if (expq.size() == 0) chk(1'b0, "R10 unexpected latch", item, 0);
    else begin
      logic [9:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      chk(item == e, t, item, e);
    end
    if (item == 10'h230) begin confirmed = 1; pc = 0; stat = 8'h80; end
    else if (item == 10'h270) begin
      pc++;
      stat = (pc > busy_k) ? (8'hC0 | ecc_v) : 8'h80;
    end else if (item == 10'h200 && confirmed) begin
      confirmed = 0;
      t_final = $time;
      if (rdy_len > 0) fork
        begin
          repeat (3) @(negedge clk);
          nand_rdy = 1'b0;
          repeat (rdy_len) @(negedge clk);
          nand_rdy = 1'b1;
        end
      join_none
    end
  end

  task automatic run(input logic [23:0] pg, input logic [15:0] col, input bit wide,
                     input bit big, input bit spare, input int k, input logic [7:0] ecc,
                     input int rlen, input bit poke, input string tag);
    logic [16:0] sum;
    logic [15:0] ce;
    int npoll, dcyc;
    bit ready;
    sum = {1'b0, col} + (spare ? 17'(PAGE_B) : 17'd0);
    ce  = wide ? sum[16:1] : sum[15:0];
    npoll = (k + 1 < PMAX) ? k + 1 : PMAX;
    ready = (k + 1 <= PMAX);
    push(1, 0, 8'h00, {tag, " R1 open cmd"});
    push(0, 1, ce[7:0], {tag, " R3 R4 col lo"});
    push(0, 1, ce[15:8], {tag, " R3 R4 col hi"});
    push(0, 1, pg[7:0], {tag, " R1 page b0"});
    push(0, 1, pg[15:8], {tag, " R1 page b1"});
    if (big) push(0, 1, pg[23:16], {tag, " R2 page b2"});
    push(1, 0, 8'h30, {tag, " R2 confirm"});
    for (int i = 0; i < npoll; i++) push(1, 0, 8'h70, {tag, " R5 status cmd"});
    push(1, 0, 8'h00, {tag, " R8 closing cmd"});
    busy_k = k; ecc_v = ecc; rdy_len = rlen;
    if (ready) begin
      exp_fail += ecc[0];
      exp_fix  += ecc[3];
    end else exp_to = 1;

    @(negedge clk);
    chk(req_ready, {tag, " R10 idle ready"}, req_ready, 1);
    req_page = pg; req_col = col; req_wide = wide; req_big = big; req_spare = spare;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      req_page = 24'hFFFFFF; req_col = 16'hFFFF; req_valid = 1'b1;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        chk(!req_ready, {tag, " R10 busy not ready"}, req_ready, 0);
      end
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    dcyc = int'(($time - t_final) / 8);
    chk(expq.size() == 0, {tag, " R5 all latches seen"}, expq.size(), 0);
    chk(done_status == (ready ? (8'hC0 | ecc) : 8'h80), {tag, " R9 done status"},
        done_status, ready ? (8'hC0 | ecc) : 8'h80);
    chk(ecc_fail_cnt == CNT_W'(exp_fail), {tag, " R6 fail count"}, ecc_fail_cnt, exp_fail);
    chk(ecc_fix_cnt == CNT_W'(exp_fix), {tag, " R6 fix count"}, ecc_fix_cnt, exp_fix);
    chk(poll_timeout == exp_to, {tag, " R7 timeout flag"}, poll_timeout, exp_to);
    chk(dcyc >= TWB + 2, {tag, " R9 tWB floor"}, dcyc, TWB + 2);
    if (rlen > 0) chk(dcyc >= 3 + rlen, {tag, " R9 waits rdy"}, dcyc, 3 + rlen);
    @(negedge clk);
    chk(!done, {tag, " R9 done one cycle"}, done, 0);
    chk(req_ready, {tag, " R10 back to idle"}, req_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n, "R11 strobes idle", {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
    chk(!nand_cle && !nand_ale && !nand_dq_oe, "R11 latches idle", {nand_cle, nand_ale, nand_dq_oe}, 0);
    chk(ecc_fix_cnt == 0 && ecc_fail_cnt == 0, "R11 counters zero", ecc_fix_cnt + ecc_fail_cnt, 0);
    chk(!poll_timeout && req_ready, "R11 flags", {poll_timeout, req_ready}, 2'b01);

    run(24'h012345, 16'h0010, 0, 0, 0, 0,   8'h00, 20, 0, "t1 small");
    run(24'hA5B6C7, 16'h0200, 0, 1, 0, 3,   8'h08, 20, 0, "t2 big fix");
    run(24'h000102, 16'h0123, 1, 0, 0, 1,   8'h01, 0,  0, "t3 wide fail");
    run(24'h0F0E0D, 16'h0010, 0, 1, 1, 2,   8'h09, 20, 0, "t4 spare both");
    run(24'h112233, 16'h0010, 1, 0, 1, 0,   8'h00, 5,  0, "t5 spare wide");
    run(24'h445566, 16'h0040, 0, 0, 0, 2,   8'h00, 20, 1, "t6 busy request");
    run(24'h778899, 16'h0000, 0, 1, 0, 100, 8'h09, 20, 0, "t7 timeout");
    run(24'h000001, 16'h0001, 0, 0, 0, 0,   8'h08, 20, 0, "t8 after timeout");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule